// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped management master for Clause 22 MDIO. Software loads a PHY and register number into an address register. It then starts a write by storing 16 bits of data into a data-out register, or starts a read by setting a command register to the read value. The block serialises a complete 64-bit frame on MDIO with the management clock MDC. For reads it releases the line during turnaround and the data bits, and captures the returned bits into a read-data register. Software polls a busy register until the frame completes.

MDC is derived from the system clock. A 4-bit index in the configuration register selects the divide ratio from a fixed, non-uniform table. A reset bit in the same register aborts any frame in progress and holds the engine idle while it stays set.

Top module: `mdio_master`

## Requirements
- R1: Register offsets are: 0 configuration, 1 command, 2 address, 3 data-out, 4 read-data, 5 busy. A write to offset 3 while idle starts a write frame. The frame is sent MSB first: 32 ones, then 01, then opcode 01, then 5-bit PHY address, then 5-bit register address, then turnaround 10, then the 16 data bits. MDIO output-enable is high for all 64 bits.
- R2: Writing 1 in bit 0 of the command register while idle starts a read frame with opcode 10. Output-enable is low for the last 18 bits, which are the turnaround and the data.
- R3: Writing the command register with bit 0 equal to 0 never starts a transaction.
- R4: Address register bits [7:0] hold the register number and bits [15:8] hold the PHY address. Only bits [4:0] of each field go into the frame.
- R5: The busy register reads 1 from the clock after a start until the frame ends, and 0 otherwise. A frame lasts exactly 64*N system clocks.
- R6: After a read, the read-data register holds the 16 captured bits in [15:0]. Bits [31:16] read as zero.
- R7: Configuration bits [3:0] select the divide ratio N from the list 4,4,6,8,10,14,20,28,34,42,50,58,66,74,82,98, indexed from 0. The index is taken when a frame starts. MDC is high for floor(N/2) clocks of each period and idles low.
- R8: MDIO output changes only at an MDC falling edge. Read data is sampled at the system edge where MDC rises.
- R9: Configuration bit 31 is the controller reset. While it is set, a running frame aborts: busy, MDC and output-enable fall within one clock, and new starts are ignored. Clearing the bit resumes normal operation.
- R10: A command or data-out write that arrives while busy is ignored. The frame in flight and the register contents stay unchanged.
- R11: After reset, all registers read 0 and MDC and output-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from offset |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions take two things for granted about the inputs. First, a register write lasts one clock. Second, mdio_i is stable around each MDC rising edge, because the far end changes it only after falling edges. The bench PHY model updates its driven bit only on MDC falling edges, and the bench issues every register access as a single-cycle strobe placed between clock edges. This keeps the stimulus inside those assumptions.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_BIT    = 46;
  localparam int DATA_BIT  = 48;
  localparam int RATIO_W   = 7;

  localparam int OFF_CFG  = 0;
  localparam int OFF_CMD  = 1;
  localparam int OFF_ADDR = 2;
  localparam int OFF_DOUT = 3;
  localparam int OFF_DIN  = 4;
  localparam int OFF_BUSY = 5;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  function automatic logic [RATIO_W-1:0] div_ratio(input logic [3:0] idx);
    logic [RATIO_W-1:0] r;
    case (idx)
      4'd0:  r = 7'd4;
      4'd1:  r = 7'd4;
      4'd2:  r = 7'd6;
      4'd3:  r = 7'd8;
      4'd4:  r = 7'd10;
      4'd5:  r = 7'd14;
      4'd6:  r = 7'd20;
      4'd7:  r = 7'd28;
      4'd8:  r = 7'd34;
      4'd9:  r = 7'd42;
      4'd10: r = 7'd50;
      4'd11: r = 7'd58;
      4'd12: r = 7'd66;
      4'd13: r = 7'd74;
      4'd14: r = 7'd82;
      default: r = 7'd98;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [IDX_W-1:0] div_idx_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [RATIO_W-1:0] ratio_q, cnt_q, cnt_nxt, low_len;
  logic               mdc_q;

  assign low_len = ratio_q - (ratio_q >> 1);
  assign cnt_nxt = (cnt_q >= ratio_q - 7'd1) ? '0 : cnt_q + 7'd1;
  assign rise_o  = run_i && (cnt_q == low_len - 7'd1);
  assign fall_o  = run_i && (cnt_q == ratio_q - 7'd1);
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= 7'd4;
      cnt_q   <= '0;
      mdc_q   <= 1'b0;
    end else if (!run_i) begin
      // ratio latched only while idle
      ratio_q <= div_ratio(4'(div_idx_i));
      cnt_q   <= '0;
      mdc_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      mdc_q <= (cnt_nxt >= low_len);
    end
  end

  p_mdc_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);

  p_mdc_edge_on_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(mdc_q)) |-> $past(rise_o || fall_o));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             op_read_i,
  input  logic [PHY_W-1:0] phy_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             mdo_o,
  output logic             oe_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

  logic                 busy_q, is_read_q, oe_q;
  logic [FRAME_LEN-1:0] sh_q, frame_w;
  logic [BIT_W-1:0]     bit_q;
  logic [DW-1:0]        rdata_q;
  mdio_op_e             op_w;

  assign op_w    = op_read_i ? OP_READ : OP_WRITE;
  assign frame_w = {32'hFFFF_FFFF, 2'b01, op_w, phy_i, reg_i, 2'b10,
                    op_read_i ? {DW{1'b0}} : wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      is_read_q <= 1'b0;
      oe_q      <= 1'b0;
      sh_q      <= '0;
      bit_q     <= '0;
      rdata_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      bit_q  <= '0;
    end else if (start_i) begin
      busy_q    <= 1'b1;
      is_read_q <= op_read_i;
      sh_q      <= frame_w;
      bit_q     <= '0;
      oe_q      <= 1'b1;
      if (op_read_i) rdata_q <= '0;
    end else if (busy_q) begin
      if (rise_i && is_read_q && bit_q >= BIT_W'(DATA_BIT))
        rdata_q <= {rdata_q[DW-2:0], mdio_i};
      if (fall_i) begin
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= sh_q << 1;
          // release line from turnaround onward on reads
          oe_q  <= !(is_read_q && bit_q >= BIT_W'(TA_BIT - 1));
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign mdo_o   = sh_q[FRAME_LEN-1];
  assign oe_o    = oe_q;
  assign rdata_o = rdata_q;

  p_oe_low_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !oe_q);

  p_read_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_read_q && bit_q >= BIT_W'(TA_BIT)) |-> !oe_q);

  p_write_driven_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !is_read_q) |-> oe_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int FIELD_W  = 8;
  localparam int SEL_W    = 5;
  localparam int MD_W     = 16;
  localparam int RST_BIT  = DATA_W - 1;

  logic [IDX_W-1:0]     cfg_idx_q;
  logic                 cfg_rst_q, cmd_q;
  logic [2*FIELD_W-1:0] addr_q;
  logic [MD_W-1:0]      dout_q, din_w;
  logic                 busy_w, rise_w, fall_w, mdc_w;
  logic                 wr_cfg, wr_cmd, wr_addr, wr_dout, can_start;
  logic                 start_rd, start_wr;
  logic                 unused_wdata;

  assign wr_cfg  = reg_we_i && reg_addr_i == ADDR_W'(OFF_CFG);
  assign wr_cmd  = reg_we_i && reg_addr_i == ADDR_W'(OFF_CMD);
  assign wr_addr = reg_we_i && reg_addr_i == ADDR_W'(OFF_ADDR);
  assign wr_dout = reg_we_i && reg_addr_i == ADDR_W'(OFF_DOUT);

  assign can_start = !busy_w && !cfg_rst_q;
  assign start_rd  = wr_cmd && reg_wdata_i[0] && can_start;
  assign start_wr  = wr_dout && can_start;

  assign unused_wdata = ^reg_wdata_i[RST_BIT-1:2*FIELD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_idx_q <= '0;
      cfg_rst_q <= 1'b0;
      cmd_q     <= 1'b0;
      addr_q    <= '0;
      dout_q    <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_idx_q <= reg_wdata_i[IDX_W-1:0];
        cfg_rst_q <= reg_wdata_i[RST_BIT];
      end
      if (wr_cmd && can_start) cmd_q <= reg_wdata_i[0];
      if (wr_addr) addr_q <= reg_wdata_i[2*FIELD_W-1:0];
      if (start_wr) dout_q <= reg_wdata_i[MD_W-1:0];
    end
  end

  mdio_clkgen #(.IDX_W(IDX_W)) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_w && !cfg_rst_q),
    .div_idx_i (cfg_idx_q),
    .mdc_o     (mdc_w),
    .rise_o    (rise_w),
    .fall_o    (fall_w)
  );

  mdio_shifter #(.PHY_W(SEL_W), .REG_W(SEL_W), .DW(MD_W)) u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (cfg_rst_q),
    .start_i   (start_rd || start_wr),
    .op_read_i (start_rd),
    .phy_i     (addr_q[FIELD_W +: SEL_W]),
    .reg_i     (addr_q[SEL_W-1:0]),
    .wdata_i   (reg_wdata_i[MD_W-1:0]),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .mdio_i    (mdio_i),
    .busy_o    (busy_w),
    .mdo_o     (mdio_o),
    .oe_o      (mdio_oe_o),
    .rdata_o   (din_w)
  );

  assign mdc_o = mdc_w;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(OFF_CFG): begin
        reg_rdata_o[IDX_W-1:0] = cfg_idx_q;
        reg_rdata_o[RST_BIT]   = cfg_rst_q;
      end
      ADDR_W'(OFF_CMD):  reg_rdata_o[0] = cmd_q;
      ADDR_W'(OFF_ADDR): reg_rdata_o[2*FIELD_W-1:0] = addr_q;
      ADDR_W'(OFF_DOUT): reg_rdata_o[MD_W-1:0] = dout_q;
      ADDR_W'(OFF_DIN):  reg_rdata_o[MD_W-1:0] = din_w;
      ADDR_W'(OFF_BUSY): reg_rdata_o[0] = busy_w;
      default: ;
    endcase
  end

  p_cmd_zero_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !reg_wdata_i[0] && !busy_w) |=> !busy_w);

  p_rst_clears_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_q |=> !busy_w);

  p_busy_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && (wr_dout || wr_cmd)) |=> ($stable(dout_q) && $stable(cmd_q)));

  p_mdo_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && $past(busy_w) && !$stable(mdio_o)) |-> !mdc_w);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_i;

  int n_chk = 0;
  int n_err = 0;
  logic        phy_drv = 1'b1;
  int          phy_bit = 0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap = '0;

  always #2.5 clk_i = ~clk_i;

  assign mdio_i = mdio_oe_o ? mdio_o : phy_drv;

  mdio_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) begin
    cap = {cap[62:0], mdio_i};
    phy_bit = phy_bit + 1;
  end

  always @(negedge mdc_o) begin
    if (phy_bit >= 48 && phy_bit < 64) phy_drv = phy_data[63 - phy_bit];
    else if (phy_bit == 47) phy_drv = 1'b0;
    else phy_drv = 1'b1;
  end

  function automatic int ratio_of(input int idx);
    case (idx)
      0, 1: return 4;
      2: return 6;
      3: return 8;
      4: return 10;
      5: return 14;
      6: return 20;
      7: return 28;
      default: return 34 + (idx - 8) * 8 + ((idx == 15) ? 8 : 0);
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic measure(output int busy_c, output int hi_c, output int oelo_c, output int bad_c);
    logic pm, pd;
    busy_c = 0; hi_c = 0; oelo_c = 0; bad_c = 0;
    reg_addr_i = 3'd5;
    #1;
    pm = mdc_o; pd = mdio_o;
    while (reg_rdata_o[0]) begin
      busy_c++;
      if (mdc_o) hi_c++;
      if (!mdio_oe_o) oelo_c++;
      if (mdio_o !== pd && mdc_o) bad_c++;
      pm = mdc_o; pd = mdio_o;
      @(negedge clk_i);
      #1;
    end
  endtask

  function automatic logic [63:0] wframe(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] rframe(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 2'b10, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bc, hc, oc, xc, n;
    repeat (4) @(negedge clk_i);
    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11 reg reset", 64'(v), 64'h0);
    end
    chk("R11 mdc/oe reset", {62'h0, mdc_o, mdio_oe_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R4 R5 R7 R8: write sweep over every divider index
    for (int i = 0; i < 16; i++) begin
      logic [7:0] ph, rg;
      logic [15:0] dd;
      ph = 8'hA0 + 8'(i * 3);
      rg = 8'h40 + 8'(i * 5);
      dd = 16'h1234 ^ 16'(i * 16'h0F0F);
      n = ratio_of(i);
      wr(3'd0, 32'(i));
      wr(3'd2, {16'h0, ph, rg});
      phy_bit = 0;
      wr(3'd3, {16'hBEEF, dd});
      measure(bc, hc, oc, xc);
      chk("R5 write duration", 64'(bc), 64'(64 * n));
      chk("R7 mdc high time", 64'(hc), 64'(32 * n));
      chk("R1 oe driven all bits", 64'(oc), 64'h0);
      chk("R8 mdio changes only while mdc low", 64'(xc), 64'h0);
      chk("R1 R4 write frame", cap, wframe(ph[4:0], rg[4:0], dd));
      rd(3'd5, v);
      chk("R5 busy idle", 64'(v), 64'h0);
      chk("R7 mdc idle low", 64'(mdc_o), 64'h0);
    end

    // R2 R3 R6 reads with several data patterns
    for (int k = 0; k < 5; k++) begin
      logic [15:0] pats [5];
      int idx;
      pats = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h0000};
      idx = (k == 4) ? 3 : k % 3;
      n = ratio_of(idx);
      wr(3'd0, 32'(idx));
      wr(3'd1, 32'h0);
      repeat (20) @(negedge clk_i);
      rd(3'd5, v);
      chk("R3 cmd zero no start", 64'(v), 64'h0);
      wr(3'd2, {16'h0, 8'h1F - 8'(k), 8'h02 + 8'(k)});
      phy_data = pats[k];
      phy_bit = 0;
      phy_drv = 1'b1;
      wr(3'd1, 32'h1);
      measure(bc, hc, oc, xc);
      chk("R5 read duration", 64'(bc), 64'(64 * n));
      chk("R2 oe released 18 bits", 64'(oc), 64'(18 * n));
      chk("R2 read frame", cap, rframe(5'h1F - 5'(k), 5'h02 + 5'(k), pats[k]));
      rd(3'd4, v);
      chk("R6 read data", 64'(v), {48'h0, pats[k]});
      wr(3'd1, 32'h0);
      rd(3'd1, v);
      chk("R3 cmd cleared", 64'(v), 64'h0);
    end

    // R10 writes while busy ignored
    wr(3'd0, 32'd2);
    wr(3'd2, 32'h0305);
    phy_bit = 0;
    wr(3'd3, 32'h0000_5A5A);
    repeat (50) @(negedge clk_i);
    wr(3'd3, 32'h0000_1111);
    wr(3'd1, 32'h1);
    rd(3'd1, v);
    chk("R10 cmd unchanged", 64'(v), 64'h0);
    rd(3'd3, v);
    chk("R10 data-out unchanged", 64'(v), 64'h5A5A);
    measure(bc, hc, oc, xc);
    chk("R10 frame untouched", cap, wframe(5'h03, 5'h05, 16'h5A5A));
    chk("R10 no read opened", 64'(oc), 64'h0);

    // R9 controller reset aborts and blocks
    wr(3'd0, 32'd7);
    phy_bit = 0;
    wr(3'd3, 32'h0000_C0DE);
    repeat (300) @(negedge clk_i);
    wr(3'd0, 32'h8000_0007);
    @(negedge clk_i);
    chk("R9 abort clears outputs", {61'h0, dut_i.reg_rdata_o[0] & 1'b0, mdc_o, mdio_oe_o}, 64'h0);
    rd(3'd5, v);
    chk("R9 busy cleared", 64'(v), 64'h0);
    wr(3'd3, 32'h0000_1234);
    repeat (10) @(negedge clk_i);
    rd(3'd5, v);
    chk("R9 start ignored in reset", 64'(v), 64'h0);
    rd(3'd0, v);
    chk("R9 cfg readback", 64'(v), 64'h8000_0007);
    wr(3'd0, 32'd7);
    phy_bit = 0;
    wr(3'd3, 32'h0000_0F0F);
    measure(bc, hc, oc, xc);
    chk("R9 resume duration", 64'(bc), 64'(64 * 28));
    chk("R9 resume frame", cap, wframe(5'h03, 5'h05, 16'h0F0F));

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule